// File: doc/BRIEF.md
# Per-Group Write Ownership Gate for a GPIO Bank

This block sits in front of the control registers of a GPIO bank made of `GRP_CNT` groups of `GROUP_W` pins (four groups of eight by default). Three masters share one write port: the main host, an LPC host and a coprocessor. Each write carries a 2-bit master tag. Every group has a 2-bit owner code. Only the owner of a group may change that group's slices of the output data, direction and interrupt-enable registers. In a write, the slices of groups the writer does not own are masked off, and the slices of groups it does own are updated normally.

The owner code of each group is stored as two bits in two separate source registers. The low bit is in one register and the high bit is in the other, both at bit position `GROUP_W*g`. Only the main host can write the source registers. To hand a group between the host and the coprocessor without passing through the reserved code, software writes the high-bit register first and then the low-bit register. The debounce-select register is shared by all masters and is not gated.

If a group's owner code ever becomes the reserved value 3, that group refuses writes from every master. A per-group error flag is raised one cycle later. The flag stays set until reset, and the group stays locked until reset even if the code is later repaired.

Top module: `gpio_cmd_gate`

## Requirements
- R1: After reset, all register outputs (`pinOut`, `pinDir`, `irqEnable`, `debounceSel`, `srcLow`, `srcHigh`) are zero, so every group is owned by the main host, and `errFlag` is zero.
- R2: A write with `wrEn` high updates the addressed register on the next rising clock edge. Register select `wrAddr` uses these values: 0 output data, 1 direction, 2 interrupt enable, 3 debounce select, 4 low source bits, 5 high source bits.
- R3: In a write to register 0, 1 or 2, the slice `[GROUP_W*g +: GROUP_W]` changes only if `wrMaster` equals group g's owner code. In the same write, the slices of groups owned by another master keep their old values.
- R4: Owner code of group g = {`srcHigh[GROUP_W*g]`, `srcLow[GROUP_W*g]`}. The codes are 0 main host, 1 LPC host, 2 coprocessor, 3 reserved. `wrMaster` uses the same encoding.
- R5: The source registers (select values 4 and 5) change only on writes tagged with master 0. Only bit `GROUP_W*g` of each group is stored; every other bit reads as zero.
- R6: Any master may write the debounce-select register (select 3), whatever the owner codes are.
- R7: While a group's code is 3, no master can change its slices. Its `errFlag` bit is set one cycle after the code first holds 3. The flag stays set, and the group stays locked, until reset.
- R8: Handing a group from host to coprocessor or back by writing the high-bit register before the low-bit register never sets `errFlag`.
- R9: Writes with `wrAddr` 6 or 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrMaster | input | 2 | Master tag of the write (0 host, 1 LPC, 2 coprocessor) |
| wrAddr | input | 3 | Register select |
| wrData | input | GRP_CNT*GROUP_W | Write data |
| pinOut | output | GRP_CNT*GROUP_W | Output data register |
| pinDir | output | GRP_CNT*GROUP_W | Direction register (1 = drive) |
| irqEnable | output | GRP_CNT*GROUP_W | Interrupt enable register |
| debounceSel | output | GRP_CNT*GROUP_W | Debounce select register, not gated |
| srcLow | output | GRP_CNT*GROUP_W | Owner code low bits at positions GROUP_W*g |
| srcHigh | output | GRP_CNT*GROUP_W | Owner code high bits at positions GROUP_W*g |
| errFlag | output | GRP_CNT | Sticky per-group reserved-code flag |

## Verification
A wrong owner decode shows up on the very next clock edge, as a group slice of `pinOut`, `pinDir` or `irqEnable` that moves when it should hold, or holds when it should move. Mixed-owner writes are used to expose a mask applied to the wrong group. A lock that does not persist is only visible after the code is repaired, so the bench writes to a locked group both while the code is 3 and after the code is cleared. The error flag is sampled one cycle after the code is stored, which catches both a missing flag and a flag raised a cycle early.

// File: rtl/gpio_own_pkg.sv
package gpio_own_pkg;
  localparam int GRP_CNT = 4;

  // owner and master codes
  localparam logic [1:0] SRC_HOST  = 2'd0;
  localparam logic [1:0] SRC_LPC   = 2'd1;
  localparam logic [1:0] SRC_COPRO = 2'd2;
  localparam logic [1:0] SRC_BAD   = 2'd3;

  // register selects
  localparam logic [2:0] SEL_OUT  = 3'd0;
  localparam logic [2:0] SEL_DIR  = 3'd1;
  localparam logic [2:0] SEL_IRQ  = 3'd2;
  localparam logic [2:0] SEL_DEB  = 3'd3;
  localparam logic [2:0] SEL_SRC0 = 3'd4;
  localparam logic [2:0] SEL_SRC1 = 3'd5;

  typedef struct packed {
    logic [GRP_CNT-1:0] outWe;
    logic [GRP_CNT-1:0] dirWe;
    logic [GRP_CNT-1:0] irqWe;
    logic               debWe;
    logic               src0We;
    logic               src1We;
  } strobe_t;
endpackage

// File: rtl/gpio_own_ctrl.sv
module gpio_own_ctrl
  import gpio_own_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrMaster,
  input  logic [2:0]         wrAddr,
  input  logic [GRP_CNT-1:0] ownLo,
  input  logic [GRP_CNT-1:0] ownHi,
  output strobe_t            stb,
  output logic [GRP_CNT-1:0] errFlag
);
  logic [GRP_CNT-1:0] grant;
  logic [GRP_CNT-1:0] errQ;
  logic               hostWr;

  for (genvar g = 0; g < GRP_CNT; g++) begin : gGrp
    logic [1:0] code;
    logic       locked;
    assign code   = {ownHi[g], ownLo[g]};
    assign locked = (code == SRC_BAD) || errQ[g];
    assign grant[g] = wrEn && !locked && (code == wrMaster);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 errQ[g] <= 1'b0;
      else if (code == SRC_BAD)  errQ[g] <= 1'b1;
    end
  end

  assign hostWr = wrEn && (wrMaster == SRC_HOST);

  always_comb begin
    stb.outWe  = (wrAddr == SEL_OUT) ? grant : '0;
    stb.dirWe  = (wrAddr == SEL_DIR) ? grant : '0;
    stb.irqWe  = (wrAddr == SEL_IRQ) ? grant : '0;
    stb.debWe  = wrEn && (wrAddr == SEL_DEB);
    stb.src0We = hostWr && (wrAddr == SEL_SRC0);
    stb.src1We = hostWr && (wrAddr == SEL_SRC1);
  end

  assign errFlag = errQ;

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errQ & $past(errQ)) == $past(errQ));
endmodule

// File: rtl/gpio_own_dp.sv
module gpio_own_dp
  import gpio_own_pkg::*;
#(
  parameter  int GROUP_W = 8,
  localparam int BANK_W  = GRP_CNT * GROUP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [BANK_W-1:0]  wrData,
  output logic [BANK_W-1:0]  outQ,
  output logic [BANK_W-1:0]  dirQ,
  output logic [BANK_W-1:0]  irqQ,
  output logic [BANK_W-1:0]  debQ,
  output logic [GRP_CNT-1:0] ownLo,
  output logic [GRP_CNT-1:0] ownHi,
  output logic [BANK_W-1:0]  srcLowWord,
  output logic [BANK_W-1:0]  srcHighWord
);
  for (genvar g = 0; g < GRP_CNT; g++) begin : gSlice
    localparam int LSB = g * GROUP_W;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outQ[LSB +: GROUP_W] <= '0;
        dirQ[LSB +: GROUP_W] <= '0;
        irqQ[LSB +: GROUP_W] <= '0;
        ownLo[g]             <= 1'b0;
        ownHi[g]             <= 1'b0;
      end else begin
        if (stb.outWe[g]) outQ[LSB +: GROUP_W] <= wrData[LSB +: GROUP_W];
        if (stb.dirWe[g]) dirQ[LSB +: GROUP_W] <= wrData[LSB +: GROUP_W];
        if (stb.irqWe[g]) irqQ[LSB +: GROUP_W] <= wrData[LSB +: GROUP_W];
        if (stb.src0We)   ownLo[g]             <= wrData[LSB];
        if (stb.src1We)   ownHi[g]             <= wrData[LSB];
      end
    end

    assign srcLowWord[LSB +: GROUP_W]  = {{(GROUP_W-1){1'b0}}, ownLo[g]};
    assign srcHighWord[LSB +: GROUP_W] = {{(GROUP_W-1){1'b0}}, ownHi[g]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          debQ <= '0;
    else if (stb.debWe) debQ <= wrData;
  end
endmodule

// File: rtl/gpio_cmd_gate.sv
module gpio_cmd_gate
  import gpio_own_pkg::*;
#(
  parameter  int GROUP_W = 8,
  localparam int BANK_W  = GRP_CNT * GROUP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrMaster,
  input  logic [2:0]         wrAddr,
  input  logic [BANK_W-1:0]  wrData,
  output logic [BANK_W-1:0]  pinOut,
  output logic [BANK_W-1:0]  pinDir,
  output logic [BANK_W-1:0]  irqEnable,
  output logic [BANK_W-1:0]  debounceSel,
  output logic [BANK_W-1:0]  srcLow,
  output logic [BANK_W-1:0]  srcHigh,
  output logic [GRP_CNT-1:0] errFlag
);
  strobe_t            stb;
  logic [GRP_CNT-1:0] ownLo;
  logic [GRP_CNT-1:0] ownHi;

  gpio_own_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMaster(wrMaster), .wrAddr(wrAddr),
    .ownLo(ownLo), .ownHi(ownHi), .stb(stb), .errFlag(errFlag)
  );

  gpio_own_dp #(.GROUP_W(GROUP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .outQ(pinOut), .dirQ(pinDir), .irqQ(irqEnable), .debQ(debounceSel),
    .ownLo(ownLo), .ownHi(ownHi), .srcLowWord(srcLow), .srcHighWord(srcHigh)
  );

  for (genvar g = 0; g < GRP_CNT; g++) begin : gChk
    localparam int LSB = g * GROUP_W;
    // R3
    owner_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(pinOut[LSB +: GROUP_W]) |->
        ($past(wrEn) && $past(wrAddr) == SEL_OUT &&
         $past(wrMaster) == {$past(srcHigh[LSB]), $past(srcLow[LSB])}));
    // R7
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      errFlag[g] |=> $stable(pinDir[LSB +: GROUP_W]));
  end

  // R5
  src_host_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(srcLow) |-> ($past(wrEn) && $past(wrMaster) == SRC_HOST));
  // R6
  deb_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(debounceSel) |-> ($past(wrEn) && $past(wrAddr) == SEL_DEB));
endmodule

// File: tb/sim_gpio_cmd_gate.sv
`timescale 1ns/1ps
module sim_gpio_cmd_gate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrMaster = '0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] pinOut, pinDir, irqEnable, debounceSel, srcLow, srcHigh;
  logic [3:0]  errFlag;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gpio_cmd_gate u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMaster(wrMaster), .wrAddr(wrAddr),
    .wrData(wrData), .pinOut(pinOut), .pinDir(pinDir), .irqEnable(irqEnable),
    .debounceSel(debounceSel), .srcLow(srcLow), .srcHigh(srcHigh), .errFlag(errFlag)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [2:0]  a;
    logic [31:0] d;
    logic [2:0]  sel;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 32'hAABBCCDD, 3'd0, 32'hAABBCCDD, 4'd2}, // R2 host owns all
    '{2'd1, 3'd1, 32'hFFFFFFFF, 3'd1, 32'h00000000, 4'd3}, // R3 LPC owns none
    '{2'd2, 3'd3, 32'h12345678, 3'd3, 32'h12345678, 4'd6}, // R6 coproc debounce
    '{2'd1, 3'd4, 32'hFFFFFFFF, 3'd4, 32'h00000000, 4'd5}, // R5 LPC cannot set source
    '{2'd0, 3'd4, 32'h000000FF, 3'd4, 32'h00000001, 4'd5}, // R5 only bit 0 stored
    '{2'd1, 3'd0, 32'h11111111, 3'd0, 32'hAABBCC11, 4'd4}, // R4 group0 now LPC
    '{2'd0, 3'd0, 32'h00000000, 3'd0, 32'h00000011, 4'd3}, // R3 host masked on group0
    '{2'd0, 3'd5, 32'h01000000, 3'd5, 32'h01000000, 4'd8}, // R8 high bit first
    '{2'd2, 3'd2, 32'hFFFFFFFF, 3'd2, 32'hFF000000, 4'd4}, // R4 coproc owns group3
    '{2'd0, 3'd2, 32'h0000FFFF, 3'd2, 32'hFF00FF00, 4'd3}, // R3 mixed owners
    '{2'd0, 3'd5, 32'h00000000, 3'd5, 32'h00000000, 4'd8}, // R8 hand back to host
    '{2'd0, 3'd2, 32'h00000000, 3'd2, 32'h00000000, 4'd3}, // R3 group3 host again
    '{2'd0, 3'd6, 32'hFFFFFFFF, 3'd0, 32'h00000011, 4'd9}, // R9 select 6
    '{2'd0, 3'd7, 32'hFFFFFFFF, 3'd1, 32'h00000000, 4'd9}  // R9 select 7
  };

  function automatic logic [31:0] pick(input logic [2:0] s);
    case (s)
      3'd0: return pinOut;
      3'd1: return pinDir;
      3'd2: return irqEnable;
      3'd3: return debounceSel;
      3'd4: return srcLow;
      default: return srcHigh;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] m, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrMaster = m; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pinOut | pinDir | irqEnable | debounceSel | srcLow | srcHigh, 32'h0, 1);
    check({28'h0, errFlag}, 32'h0, 1);

    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i].m, VEC[i].a, VEC[i].d);
      check(pick(VEC[i].sel), VEC[i].exp, int'(VEC[i].req));
      @(negedge clk);
      check({28'h0, errFlag}, 32'h0, 8); // R8 no error during handovers
    end

    // R7 drive group1 to reserved code 3
    doWrite(2'd0, 3'd5, 32'h00000100);
    doWrite(2'd0, 3'd4, 32'h00000101);
    check({28'h0, errFlag}, 32'h0, 7);  // flag not yet set
    @(negedge clk);
    check({28'h0, errFlag}, 32'h2, 7);  // R7 flag one cycle later
    doWrite(2'd0, 3'd1, 32'hFFFFFFFF);
    check(pinDir, 32'hFFFF0000, 7);     // R7 group1 locked, group0 LPC
    doWrite(2'd2, 3'd1, 32'h00000000);
    check(pinDir, 32'hFFFF0000, 7);     // R7 coproc owns nothing
    doWrite(2'd0, 3'd5, 32'h00000000);
    doWrite(2'd0, 3'd4, 32'h00000000);
    check(srcLow | srcHigh, 32'h0, 5);
    doWrite(2'd0, 3'd1, 32'h0000FFFF);
    check(pinDir, 32'h000000FF, 7);     // R7 lock persists after repair
    check({28'h0, errFlag}, 32'h2, 7);  // R7 flag sticky

    // R1 reset mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pinOut | pinDir | irqEnable | debounceSel | srcLow | srcHigh, 32'h0, 1);
    check({28'h0, errFlag}, 32'h0, 1);
    doWrite(2'd0, 3'd1, 32'h0000FF00);
    check(pinDir, 32'h0000FF00, 2);     // R2 group1 writable again

    finishRun();
  end
endmodule